// File: doc/BRIEF.md
# Interrupt-Capable Dual 8-Bit GPIO Port

This block provides two 8-bit general-purpose I/O ports behind a small register interface. Each bit can be an input or an output on its own terms, and any bit can raise an interrupt on a rising or falling edge chosen per bit. Incoming pin levels pass through a two-flop synchronizer before they are read or examined for edges, so asynchronous pins are safe to connect directly.

Software sees six register kinds, selected by a 3-bit address. Every access covers both ports at once as a 16-bit word: port 0 sits in the low byte and port 1 in the high byte. Two byte-lane strobes let software write one port alone or both in the same cycle. Reads always return the full word. A single interrupt request combines the enabled flags of all sixteen bits and stays high until software clears the flags behind it.

Top module: `pinpair_gpio`

## Requirements
- R1: While reset is low, and on leaving it, every writable register reads 0, `pin_out` and `pin_oe` are 0 and `irq` is low.
- R2: The output register (address 1) drives `pin_out`. The direction register (address 2) drives `pin_oe`, where a 1 makes that bit an output. Both take a written value on the clock edge of the write.
- R3: The input register (address 0) returns each pin as sampled two clock edges earlier. Writes to address 0 change nothing.
- R4: With edge-select bit 0 (address 4), a flag bit (address 3) sets on a rising edge of its synchronized input. With edge-select bit 1, it sets on a falling edge. A pin change made between clock edges shows in the flag after the third following rising clock edge.
- R5: A flag write loads the written value, so writing 0 clears a bit and writing 1 sets it. If an edge event on a bit lands in the same cycle as a write of 0 to that bit, the flag ends up set.
- R6: `irq` is high exactly when some bit has both its flag and its enable (address 5) set. It stays high until software clears those flags or enables.
- R7: `bus_be[0]` enables the write of the low byte (port 0, pins 7:0) and `bus_be[1]` enables the high byte (port 1, pins 15:8). With both strobes set, both bytes update in one cycle. A byte whose strobe is low keeps its value. Reads return both ports as one word.
- R8: Addresses 6 and 7 read as 0, and writes to them change no register.
- R9: Each bit is independent. An edge on one bit sets only that bit's flag, and the bits of a port can mix inputs, outputs and interrupt use freely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register kind select |
| bus_be | input | 2 | Byte-lane write enables, bit 0 = port 0 |
| bus_wdata | input | 16 | Write data, port 0 in bits 7:0 |
| bus_rdata | output | 16 | Read data for the selected register |
| pin_in | input | 16 | Raw pin levels, asynchronous |
| pin_out | output | 16 | Output levels |
| pin_oe | output | 16 | Output enables, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check several rules at each port. A selected edge always leaves its flag set. A flag never rises without an event or a write. An event beats a same-cycle clear. The direction register follows its writes. An unmapped address reads zero. The interrupt line holds while nothing touches its flags or enables. What only the bench scenarios can show involves a behavioural model compared on every clock. That comparison covers the exact three-edge latency from pin to flag, the per-lane write masking, the read-only input register, and the cycle-exact collision of a clear with an edge event.

// File: rtl/pinpair_pkg.sv
package pinpair_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_IN   = 3'd0,
    REG_OUT  = 3'd1,
    REG_DIR  = 3'd2,
    REG_FLAG = 3'd3,
    REG_EDGE = 3'd4,
    REG_EN   = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/pinpair_sync.sv
module pinpair_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/pinpair_port.sv
module pinpair_port
  import pinpair_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      rdata_o,
  output logic [W-1:0]      pin_out_o,
  output logic [W-1:0]      pin_oe_o,
  output logic              irq_o
);
  logic [W-1:0] sync_val;
  logic [W-1:0] out_q, dir_q, flag_q, edge_q, en_q, prev_q;
  logic [W-1:0] out_d, dir_d, flag_d, edge_d, en_d;
  logic [W-1:0] rise, fall, evt;
  logic         wr_out, wr_dir, wr_flag, wr_edge, wr_en_r;

  pinpair_sync #(.W(W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pin_i),
    .q_o  (sync_val)
  );

  // edge detection on the synchronized value
  assign rise = sync_val & ~prev_q;
  assign fall = ~sync_val & prev_q;
  assign evt  = (edge_q & fall) | (~edge_q & rise);

  assign wr_out  = wr_en && (addr == REG_OUT);
  assign wr_dir  = wr_en && (addr == REG_DIR);
  assign wr_flag = wr_en && (addr == REG_FLAG);
  assign wr_edge = wr_en && (addr == REG_EDGE);
  assign wr_en_r = wr_en && (addr == REG_EN);

  always_comb begin
    out_d  = wr_out  ? wdata : out_q;
    dir_d  = wr_dir  ? wdata : dir_q;
    edge_d = wr_edge ? wdata : edge_q;
    en_d   = wr_en_r ? wdata : en_q;
    // an edge event overrides a simultaneous clear
    flag_d = (wr_flag ? wdata : flag_q) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      flag_q <= '0;
      edge_q <= '0;
      en_q   <= '0;
      prev_q <= '0;
    end else begin
      out_q  <= out_d;
      dir_q  <= dir_d;
      flag_q <= flag_d;
      edge_q <= edge_d;
      en_q   <= en_d;
      prev_q <= sync_val;
    end
  end

  always_comb begin
    case (addr)
      REG_IN:   rdata_o = sync_val;
      REG_OUT:  rdata_o = out_q;
      REG_DIR:  rdata_o = dir_q;
      REG_FLAG: rdata_o = flag_q;
      REG_EDGE: rdata_o = edge_q;
      REG_EN:   rdata_o = en_q;
      default:  rdata_o = '0;
    endcase
  end

  assign pin_out_o = out_q;
  assign pin_oe_o  = dir_q;
  assign irq_o     = |(flag_q & en_q);

  assert_flag_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flag_q & $past(evt)) == $past(evt)));

  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_flag) |=> ((flag_q & ~$past(flag_q) & ~$past(evt)) == '0));

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && (|evt)) |=> ((flag_q & $past(evt)) == $past(evt)));

  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pin_oe_o == $past(wdata)));

  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !wr_flag && !wr_en_r) |=> irq_o);
endmodule

// File: rtl/pinpair_gpio.sv
module pinpair_gpio
  import pinpair_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int NPORTS = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [NPORTS-1:0]        bus_be,
  input  logic [PORT_W*NPORTS-1:0] bus_wdata,
  output logic [PORT_W*NPORTS-1:0] bus_rdata,
  input  logic [PORT_W*NPORTS-1:0] pin_in,
  output logic [PORT_W*NPORTS-1:0] pin_out,
  output logic [PORT_W*NPORTS-1:0] pin_oe,
  output logic                     irq
);
  logic [NPORTS-1:0] port_irq;

  for (genvar gi = 0; gi < NPORTS; gi++) begin : g_port
    pinpair_port #(.W(PORT_W)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr && bus_be[gi]),
      .addr     (bus_addr),
      .wdata    (bus_wdata[gi*PORT_W +: PORT_W]),
      .pin_i    (pin_in[gi*PORT_W +: PORT_W]),
      .rdata_o  (bus_rdata[gi*PORT_W +: PORT_W]),
      .pin_out_o(pin_out[gi*PORT_W +: PORT_W]),
      .pin_oe_o (pin_oe[gi*PORT_W +: PORT_W]),
      .irq_o    (port_irq[gi])
    );
  end

  assign irq = |port_irq;

  assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > ADDR_W'(REG_EN)) |-> (bus_rdata == '0));
endmodule

// File: tb/pinpair_gpio_bench.sv
`timescale 1ns/1ps
module pinpair_gpio_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pinpair_gpio u_pinpair_gpio (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference model
  logic [15:0] m_out, m_dir, m_flag, m_edge, m_en;
  logic [15:0] hist[$];
  logic [15:0] m_s2, m_pv, m_ev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = 0; m_dir = 0; m_flag = 0; m_edge = 0; m_en = 0;
      hist = {16'h0, 16'h0, 16'h0};
    end else begin
      m_s2 = hist[1];
      m_pv = hist[2];
      for (int b = 0; b < 16; b++) begin
        if (m_edge[b]) m_ev[b] = m_pv[b] && !m_s2[b];
        else           m_ev[b] = !m_pv[b] && m_s2[b];
      end
      for (int b = 0; b < 16; b++) begin
        if (bus_wr && bus_be[b/8]) begin
          case (bus_addr)
            3'd1: m_out[b]  = bus_wdata[b];
            3'd2: m_dir[b]  = bus_wdata[b];
            3'd3: m_flag[b] = bus_wdata[b];
            3'd4: m_edge[b] = bus_wdata[b];
            3'd5: m_en[b]   = bus_wdata[b];
            default: ;
          endcase
        end
        if (m_ev[b]) m_flag[b] = 1'b1;
      end
      hist.push_front(pin_in);
      void'(hist.pop_back());
    end
  end

  function automatic logic [15:0] model_read(input logic [2:0] a);
    case (a)
      3'd0: return hist[1];
      3'd1: return m_out;
      3'd2: return m_dir;
      3'd3: return m_flag;
      3'd4: return m_edge;
      3'd5: return m_en;
      default: return 16'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R2 pin_out", pin_out, m_out);
      check("R2 pin_oe", pin_oe, m_dir);
      check("R6 irq", {15'h0, irq}, {15'h0, |(m_flag & m_en)});
      check("R7 rdata", bus_rdata, model_read(bus_addr));
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    rst_n = 0; bus_wr = 0; bus_addr = 0; bus_be = 0; bus_wdata = 0; pin_in = 0;
    cycles(3);
    // R1: reset state
    for (int a = 1; a < 6; a++) begin
      rd(3'(a), v);
      check("R1 reg in reset", v, 16'h0);
    end
    check("R1 pin_oe", pin_oe, 16'h0);
    check("R1 pin_out", pin_out, 16'h0);
    check("R1 irq", {15'h0, irq}, 16'h0);
    @(negedge clk); rst_n = 1;
    rd(3'd3, v); check("R1 flag after reset", v, 16'h0);

    // R2 and R7: word and byte writes
    bus_write(3'd1, 2'b11, 16'hA55A);
    check("R2 pin_out word", pin_out, 16'hA55A);
    bus_write(3'd1, 2'b01, 16'h1234);
    rd(3'd1, v); check("R7 low lane only", v, 16'hA534);
    bus_write(3'd2, 2'b10, 16'hF00F);
    check("R7 high lane dir", pin_oe, 16'hF000);

    // R3: input register timing, read-only
    pin_in = 16'h00C3;
    cycles(1);
    rd(3'd0, v); check("R3 input after one edge", v, 16'h0000);
    cycles(1);
    rd(3'd0, v); check("R3 input after two edges", v, 16'h00C3);
    bus_write(3'd0, 2'b11, 16'hFFFF);
    rd(3'd0, v); check("R3 write ignored", v, 16'h00C3);

    // R8: unmapped addresses
    bus_write(3'd6, 2'b11, 16'hFFFF);
    bus_write(3'd7, 2'b11, 16'hFFFF);
    rd(3'd6, v); check("R8 addr 6 reads zero", v, 16'h0);
    rd(3'd7, v); check("R8 addr 7 reads zero", v, 16'h0);
    rd(3'd1, v); check("R8 out unchanged", v, 16'hA534);
    rd(3'd4, v); check("R8 edge unchanged", v, 16'h0);

    // R4 and R9: edge selection and latency
    bus_write(3'd3, 2'b11, 16'h0000);
    bus_write(3'd4, 2'b11, 16'h0100);
    pin_in = 16'h01C7;
    cycles(2);
    rd(3'd3, v); check("R4 no flag before third edge", v, 16'h0000);
    cycles(1);
    rd(3'd3, v); check("R4 rising flag, R9 bit isolation", v, 16'h0004);
    pin_in = 16'h00C7;
    cycles(3);
    rd(3'd3, v); check("R4 falling flag", v, 16'h0104);

    // R6: interrupt combine and hold
    check("R6 no irq without enable", {15'h0, irq}, 16'h0);
    bus_write(3'd5, 2'b10, 16'h0100);
    check("R6 irq with enable", {15'h0, irq}, 16'h1);
    cycles(10);
    check("R6 irq held", {15'h0, irq}, 16'h1);
    bus_write(3'd3, 2'b11, 16'h0004);
    check("R6 irq cleared", {15'h0, irq}, 16'h0);

    // R5: clear colliding with an event, and writing one
    bus_write(3'd3, 2'b11, 16'h0000);
    pin_in = 16'h00D7;
    cycles(2);
    bus_wr = 1; bus_addr = 3'd3; bus_be = 2'b11; bus_wdata = 16'h0000;
    @(negedge clk); bus_wr = 0;
    rd(3'd3, v); check("R5 event beats clear", v, 16'h0010);
    bus_write(3'd3, 2'b10, 16'h8000);
    rd(3'd3, v); check("R5 write one sets", v, 16'h8010);
    bus_write(3'd3, 2'b01, 16'h0000);
    rd(3'd3, v); check("R5 write zero clears", v, 16'h8000);

    // mixed random traffic checked against the model each cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      bus_wr    = ($urandom_range(0, 1) == 1);
      bus_addr  = 3'($urandom_range(0, 7));
      bus_be    = 2'($urandom_range(0, 3));
      bus_wdata = 16'($urandom);
      if ($urandom_range(0, 3) == 0) pin_in = pin_in ^ 16'($urandom);
    end
    @(negedge clk); bus_wr = 0;
    cycles(4);
    finish_run();
  end
endmodule